// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that counts down in its own slow clock domain, separate from the bus clock that software uses to program it. Software never writes a control bit directly. Every action is a magic value written to a key register: one value arms the counter, another refreshes it, and a third opens the prescaler and reload registers for writing. The registers close again on the next key write of any other value. Once armed, the watchdog cannot be disarmed by software. If it is not refreshed in time, the counter reaches zero and a reset pulse is issued to the system reset controller.

Prescaler and reload values are held in the bus domain and carried into the counter domain by a toggle handshake. Two busy flags show that a crossing is still in flight. Refresh and start commands cross through two-flop synchronisers as a toggle and a level. The counter divides its clock by a power of two between 4 and 256. It then counts a 12-bit value down to zero, pulses the reset output and reloads.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, the registers are locked, both busy flags are low, the reset output is low, the reload value is 0xFFF (seen on `count_o`) and the prescaler encoding is 0 (divide by 4).
- R2: Bus writes use address 0 for the key, 1 for the prescaler (data bits 2:0) and 2 for the reload value. Key value 0x5555 unlocks the prescaler and reload registers. While they are locked, writes to them are ignored and raise no busy flag.
- R3: A key write of any value other than 0x5555 re-locks the registers, including 0xAAAA and 0xCCCC.
- R4: Only bits 11:0 of a reload write are kept. The upper bits are discarded.
- R5: Prescaler encoding n in 0..6 divides the counter clock by 4·2^n. Encoding 7 divides by 256.
- R6: An accepted prescaler or reload write raises its busy flag (`pvu_busy_o`, `rvu_busy_o`) on the next bus clock. The flag drops only when the acknowledgement has returned from the counter domain. A write to a register whose flag is still high is ignored.
- R7: While stopped, the counter follows the latest carried reload value and no reset pulse is issued.
- R8: Key 0xCCCC starts the watchdog. While it runs unrefreshed with reload R and divide D, reset pulses are exactly (R+1)·D counter-clock cycles apart, and each pulse lasts one counter-clock cycle.
- R9: Once started, no key write or register write stops the watchdog.
- R10: Key 0xAAAA reloads the counter from the reload value. Refreshing more often than the timeout prevents any reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| cnt_clk_i | input | 1 | Low-speed counter clock |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 2 | Write address: 0 key, 1 prescaler, 2 reload |
| wr_data_i | input | 16 | Write data |
| pvu_busy_o | output | 1 | Prescaler update in flight |
| rvu_busy_o | output | 1 | Reload update in flight |
| count_o | output | 12 | Current down-counter value (counter domain) |
| wdt_rst_o | output | 1 | Reset pulse, one counter-clock cycle wide |

## Verification
The busy flags are due on the first bus edge after a write, so the bench samples them at the falling edge that follows the write cycle. The flags clear after a variable number of cycles because of the synchronisers. The bench therefore waits for them to drop, and then lets four counter-clock cycles pass before it reads `count_o`. Reset-pulse timing goes through a scoreboard that holds the expected spacing. The monitor measures the spacing only between two pulses that both arrive after the expectation was queued, so the first pulse after any change is never measured and synchroniser latency stays out of the count.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned RLD_W     = 12;
  localparam int unsigned PSC_W     = 3;
  localparam int unsigned PSC_CNT_W = 8;
  localparam int unsigned MAX_SHIFT = 6;

  localparam logic [1:0] ADDR_KEY = 2'd0;
  localparam logic [1:0] ADDR_PSC = 2'd1;
  localparam logic [1:0] ADDR_RLD = 2'd2;

  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;

  // last prescaler count for an encoding; encodings above MAX_SHIFT saturate
  function automatic logic [PSC_CNT_W-1:0] div_last(input logic [PSC_W-1:0] enc);
    logic [PSC_CNT_W:0] full;
    int unsigned sh;
    sh   = (int'(enc) > int'(MAX_SHIFT)) ? MAX_SHIFT : int'(enc);
    full = (PSC_CNT_W+1)'(4) << sh;
    return PSC_CNT_W'(full - 1'b1);
  endfunction
endpackage

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/kwdt_bus_regs.sv
module kwdt_bus_regs
  import kwdt_pkg::*;
#(
  parameter logic [RLD_W-1:0] RLD_RESET = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              psc_ack_i,
  input  logic              rld_ack_i,
  output logic [PSC_W-1:0]  psc_o,
  output logic [RLD_W-1:0]  rld_o,
  output logic              psc_req_o,
  output logic              rld_req_o,
  output logic              ref_tgl_o,
  output logic              start_o,
  output logic              unlock_o,
  output logic              pvu_busy_o,
  output logic              rvu_busy_o
);
  logic [PSC_W-1:0] psc_q;
  logic [RLD_W-1:0] rld_q;
  logic psc_req_q, rld_req_q, ref_q, start_q, unlock_q;
  logic key_wr, psc_wr, rld_wr;

  assign pvu_busy_o = psc_req_q ^ psc_ack_i;
  assign rvu_busy_o = rld_req_q ^ rld_ack_i;

  assign key_wr = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign psc_wr = wr_en_i && (wr_addr_i == ADDR_PSC) && unlock_q && !pvu_busy_o;
  assign rld_wr = wr_en_i && (wr_addr_i == ADDR_RLD) && unlock_q && !rvu_busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q     <= '0;
      rld_q     <= RLD_RESET;
      psc_req_q <= 1'b0;
      rld_req_q <= 1'b0;
      ref_q     <= 1'b0;
      start_q   <= 1'b0;
      unlock_q  <= 1'b0;
    end else begin
      if (key_wr) begin
        unlock_q <= (wr_data_i == KEY_UNLOCK);
        if (wr_data_i == KEY_REFRESH) ref_q   <= ~ref_q;
        if (wr_data_i == KEY_START)   start_q <= 1'b1;
      end
      if (psc_wr) begin
        psc_q     <= wr_data_i[PSC_W-1:0];
        psc_req_q <= ~psc_req_q;
      end
      if (rld_wr) begin
        rld_q     <= wr_data_i[RLD_W-1:0];
        rld_req_q <= ~rld_req_q;
      end
    end
  end

  assign psc_o     = psc_q;
  assign rld_o     = rld_q;
  assign psc_req_o = psc_req_q;
  assign rld_req_o = rld_req_q;
  assign ref_tgl_o = ref_q;
  assign start_o   = start_q;
  assign unlock_o  = unlock_q;
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
  import kwdt_pkg::*;
#(
  parameter logic [RLD_W-1:0] RLD_RESET = '1
) (
  input  logic             cnt_clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [RLD_W-1:0] rld_i,
  input  logic             psc_req_i,
  input  logic             rld_req_i,
  input  logic             ref_i,
  input  logic             start_i,
  output logic             psc_ack_o,
  output logic             rld_ack_o,
  output logic [RLD_W-1:0] count_o,
  output logic             wdt_rst_o
);
  logic [PSC_W-1:0]     psc_c;
  logic [RLD_W-1:0]     rld_c, cnt_q;
  logic [PSC_CNT_W-1:0] div_q, lim;
  logic psc_ack_q, rld_ack_q, ref_d, rst_q;
  logic refresh, tick;

  // bus-side data is held steady while its request toggle is pending
  always_ff @(posedge cnt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_c     <= '0;
      rld_c     <= RLD_RESET;
      psc_ack_q <= 1'b0;
      rld_ack_q <= 1'b0;
    end else begin
      if (psc_req_i != psc_ack_q) begin
        psc_c     <= psc_i;
        psc_ack_q <= psc_req_i;
      end
      if (rld_req_i != rld_ack_q) begin
        rld_c     <= rld_i;
        rld_ack_q <= rld_req_i;
      end
    end
  end

  assign lim     = div_last(psc_c);
  assign refresh = ref_i ^ ref_d;
  assign tick    = (div_q >= lim);   // >= covers a shrinking divider

  always_ff @(posedge cnt_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_d <= 1'b0;
      div_q <= '0;
      cnt_q <= RLD_RESET;
      rst_q <= 1'b0;
    end else begin
      ref_d <= ref_i;
      rst_q <= 1'b0;
      if (!start_i) begin
        div_q <= '0;
        cnt_q <= rld_c;
      end else if (refresh) begin
        div_q <= '0;
        cnt_q <= rld_c;
      end else if (tick) begin
        div_q <= '0;
        if (cnt_q == '0) begin
          cnt_q <= rld_c;
          rst_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign psc_ack_o = psc_ack_q;
  assign rld_ack_o = rld_ack_q;
  assign count_o   = cnt_q;
  assign wdt_rst_o = rst_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwdt_pkg::*;
#(
  parameter logic [RLD_W-1:0] RLD_RESET = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_clk_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pvu_busy_o,
  output logic              rvu_busy_o,
  output logic [RLD_W-1:0]  count_o,
  output logic              wdt_rst_o
);
  localparam int unsigned TO_CNT_W = 4;
  localparam int unsigned TO_BUS_W = 2;

  logic [PSC_W-1:0] psc_w;
  logic [RLD_W-1:0] rld_w;
  logic psc_req_w, rld_req_w, ref_w, started_w, unlock_w;
  logic psc_ack_w, rld_ack_w;
  logic [TO_CNT_W-1:0] to_cnt_s;
  logic [TO_BUS_W-1:0] to_bus_s;

  kwdt_bus_regs #(.RLD_RESET(RLD_RESET)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .psc_ack_i  (to_bus_s[0]),
    .rld_ack_i  (to_bus_s[1]),
    .psc_o      (psc_w),
    .rld_o      (rld_w),
    .psc_req_o  (psc_req_w),
    .rld_req_o  (rld_req_w),
    .ref_tgl_o  (ref_w),
    .start_o    (started_w),
    .unlock_o   (unlock_w),
    .pvu_busy_o (pvu_busy_o),
    .rvu_busy_o (rvu_busy_o)
  );

  kwdt_sync #(.W(TO_CNT_W)) u_sync_cnt (
    .clk_i  (cnt_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({started_w, ref_w, rld_req_w, psc_req_w}),
    .q_o    (to_cnt_s)
  );

  kwdt_sync #(.W(TO_BUS_W)) u_sync_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rld_ack_w, psc_ack_w}),
    .q_o    (to_bus_s)
  );

  kwdt_core #(.RLD_RESET(RLD_RESET)) u_core (
    .cnt_clk_i (cnt_clk_i),
    .rst_ni    (rst_ni),
    .psc_i     (psc_w),
    .rld_i     (rld_w),
    .psc_req_i (to_cnt_s[0]),
    .rld_req_i (to_cnt_s[1]),
    .ref_i     (to_cnt_s[2]),
    .start_i   (to_cnt_s[3]),
    .psc_ack_o (psc_ack_w),
    .rld_ack_o (rld_ack_w),
    .count_o   (count_o),
    .wdt_rst_o (wdt_rst_o)
  );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
  import kwdt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cnt_clk_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              pvu_busy_o,
  input logic              rvu_busy_o,
  input logic              wdt_rst_o,
  input logic              unlock,
  input logic              started
);
  // R2
  locked_rld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_RLD && !unlock && !rvu_busy_o) |=> !rvu_busy_o);

  // R2
  locked_psc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_PSC && !unlock && !pvu_busy_o) |=> !pvu_busy_o);

  // R3
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_KEY && wr_data_i != KEY_UNLOCK) |=> !unlock);

  // R6
  rld_busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_RLD && unlock && !rvu_busy_o) |=> rvu_busy_o);

  // R6
  psc_busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_PSC && unlock && !pvu_busy_o) |=> pvu_busy_o);

  // R9
  start_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |=> started);

  // R8
  pulse_width_chk: assert property (@(posedge cnt_clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_clk_i  (cnt_clk_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .pvu_busy_o (pvu_busy_o),
  .rvu_busy_o (rvu_busy_o),
  .wdt_rst_o  (wdt_rst_o),
  .unlock     (unlock_w),
  .started    (started_w)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  logic        clk_i = 1'b0;
  logic        cnt_clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [15:0] wr_data_i = 16'h0;
  logic        pvu_busy_o, rvu_busy_o, wdt_rst_o;
  logic [11:0] count_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  bit    have_prev = 1'b0;
  bit    prev_rst  = 1'b0;
  int    gap = 0;

  always #2.5  clk_i = ~clk_i;      // 200 MHz bus clock
  always #18.5 cnt_clk_i = ~cnt_clk_i;

  keyed_watchdog uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_clk_i(cnt_clk_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pvu_busy_o(pvu_busy_o), .rvu_busy_o(rvu_busy_o),
    .count_o(count_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pulse width and pulse spacing against the scoreboard
  always @(negedge cnt_clk_i) begin
    if (rst_ni && !done) begin
      if (prev_rst) check(!wdt_rst_o, "R8 pulse width", int'(wdt_rst_o), 0);
      if (wdt_rst_o) begin
        pulses++;
        if (exp_q.size() > 0) begin
          if (have_prev) begin
            check(gap + 1 == exp_q[0], tag_q[0], gap + 1, exp_q[0]);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end
          have_prev = (exp_q.size() > 0);
        end
        gap = 0;
      end else begin
        gap++;
      end
      prev_rst = wdt_rst_o;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cnt_wait(input int n);
    repeat (n) @(negedge cnt_clk_i);
    @(negedge clk_i);
  endtask

  task automatic wait_idle();
    while (pvu_busy_o || rvu_busy_o) @(negedge clk_i);
    cnt_wait(4);
  endtask

  task automatic expect_gap(input int cyc, input string tag);
    have_prev = 1'b0;
    exp_q.push_back(cyc);
    tag_q.push_back(tag);
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  initial begin
    int snap;
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check(count_o == 12'hFFF, "R1 reload", count_o, 12'hFFF);
    check(!pvu_busy_o && !rvu_busy_o, "R1 busy", {pvu_busy_o, rvu_busy_o}, 0);
    cnt_wait(100);
    check(pulses == 0 && !wdt_rst_o, "R1 no pulse", pulses, 0);

    // R2 locked writes ignored
    bus_wr(2'd2, 16'h0005);
    check(!rvu_busy_o, "R2 locked reload busy", rvu_busy_o, 0);
    bus_wr(2'd1, 16'h0003);
    check(!pvu_busy_o, "R2 locked psc busy", pvu_busy_o, 0);
    cnt_wait(8);
    check(count_o == 12'hFFF, "R2 locked reload value", count_o, 12'hFFF);

    // R6 busy set, write during busy dropped
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd2, 16'h0005);
    check(rvu_busy_o, "R6 reload busy", rvu_busy_o, 1);
    bus_wr(2'd2, 16'h000A);
    wait_idle();
    check(count_o == 12'h005, "R6 write while busy ignored", count_o, 5);

    // R4 upper bits dropped
    bus_wr(2'd2, 16'hF007);
    wait_idle();
    check(count_o == 12'h007, "R4 reload truncation", count_o, 7);

    // R3 relock by refresh key and by an arbitrary key
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd0, 16'hAAAA);
    bus_wr(2'd2, 16'h0009);
    check(!rvu_busy_o, "R3 relock by refresh key", rvu_busy_o, 0);
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd0, 16'h1234);
    bus_wr(2'd2, 16'h0009);
    check(!rvu_busy_o, "R3 relock by other key", rvu_busy_o, 0);
    cnt_wait(8);

    // R7 stopped: no pulse, counter shows reload
    check(count_o == 12'h007 && pulses == 0, "R7 stopped", count_o, 7);

    // R8 start; default divide 4 (R1): (7+1)*4
    bus_wr(2'd0, 16'hCCCC);
    expect_gap(32, "R8 period div4 (R1 default)");

    // R3 start key relocks
    bus_wr(2'd2, 16'h0003);
    check(!rvu_busy_o, "R3 relock by start key", rvu_busy_o, 0);

    // R5 divider encodings
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd1, 16'h0001);
    check(pvu_busy_o, "R6 prescaler busy", pvu_busy_o, 1);
    wait_idle();
    expect_gap(64, "R5 enc1 period");
    bus_wr(2'd1, 16'h0007);
    wait_idle();
    expect_gap(2048, "R5 enc7 period");
    bus_wr(2'd1, 16'h0003);
    wait_idle();
    expect_gap(256, "R5 enc3 period");

    // R9 no key stops it
    bus_wr(2'd0, 16'h0000);
    bus_wr(2'd0, 16'hFFFF);
    bus_wr(2'd0, 16'h5555);
    expect_gap(256, "R9 still running");

    // R10 refresh holds off reset
    bus_wr(2'd1, 16'h0000);
    wait_idle();
    bus_wr(2'd2, 16'h0014);
    wait_idle();
    expect_gap(84, "R10 setup period");
    bus_wr(2'd0, 16'hAAAA);
    cnt_wait(10);
    snap = pulses;
    for (int i = 0; i < 12; i++) begin
      cnt_wait(30);
      bus_wr(2'd0, 16'hAAAA);
    end
    check(pulses == snap, "R10 refresh prevents pulse", pulses - snap, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule